// File: doc/BRIEF.md
# Trapping Integer ALU with Shifter

This block is the combinational execute unit of a three-operand load/store integer pipeline. It takes two 32-bit operands, a 4-bit operation select and a 5-bit constant shift amount. It returns a 32-bit result in the same evaluation, with no register on the path.

It also returns a trap request for signed arithmetic overflow. Handling that trap belongs to the pipeline, not to this block. Immediate instruction forms reach the block by muxing an extended constant onto operand B before the block. Register moves and bitwise NOT are built from the add and xor operations.

Signed and unsigned add and subtract produce the same result bits. Only the signed forms may raise the trap.

Shifts always act on operand B. The shift amount comes from one of two places:
- the constant field, for constant shifts;
- the low five bits of operand A, for variable shifts.

Top module: `alu_trap_top`

## Requirements
- R1: Op 0 (signed add) and op 2 (signed subtract) return opA+opB and opA-opB modulo 2^32.
- R2: Op 1 (unsigned add) and op 3 (unsigned subtract) return the same bits as ops 0 and 2, and ovfTrap stays 0 for them on every input.
- R3: ovfTrap is 1 for op 0 exactly when opA and opB share bit 31 and the result's bit 31 differs from it. For op 2 the same rule applies with opB's bit 31 inverted.
- R4: Op 4 returns opA AND opB, op 5 returns opA OR opB and op 6 returns opA XOR opB. An all-ones opB with op 6 returns the bitwise NOT of opA.
- R5: Op 7 returns the bitwise inverse of (opA OR opB).
- R6: Op 8 shifts opB left by shamtImm and op 9 shifts opB right by shamtImm. Both fill the vacated bits with zeros.
- R7: Op 10 (by shamtImm) and op 13 (by register) shift opB right and fill the vacated bits with copies of opB bit 31.
- R8: Ops 11, 12 and 13 (variable left, logical right, arithmetic right) take the amount from opA[4:0]. opA[31:5] and shamtImm have no effect on them.
- R9: Op 0 with opA = 0 returns opB unchanged, with ovfTrap 0.
- R10: Op 0 with a negative opB (an inverted constant) returns opA minus its magnitude, and raises no trap unless R3 holds.
- R11: Op codes 14 and 15 return zero with ovfTrap 0.
- R12: ovfTrap is 0 for every logical and shift operation (ops 4 to 13).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | 32 | First operand; its low 5 bits are the variable shift amount |
| opB | input | 32 | Second operand, possibly an extended constant; shift source |
| opCode | input | 4 | Operation select, encoding as in the requirements |
| shamtImm | input | 5 | Constant shift amount from the instruction field |
| result | output | 32 | Operation result |
| ovfTrap | output | 1 | Signed overflow trap request |

## Verification
The bench builds the block at its default width of 32 bits and a 5-bit shift amount. At that width the overflow corners (0x7FFFFFFF+1, 0x80000000-1, 0x80000000+0x80000000) and the full shift range 0 to 31 are exact, hand-derivable values. At 32 bits the bench also reaches the ignored upper bits of a register amount, such as 0xFFFFFFE3 acting as a shift of 3. Sign fill is exercised with bit 31 both set and clear, at the boundary amounts 0, 1 and 31.

// File: rtl/alu_trap_pkg.sv
package alu_trap_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADDU = 4'd1,
    OP_SUB  = 4'd2,
    OP_SUBU = 4'd3,
    OP_AND  = 4'd4,
    OP_OR   = 4'd5,
    OP_XOR  = 4'd6,
    OP_NOR  = 4'd7,
    OP_SLL  = 4'd8,
    OP_SRL  = 4'd9,
    OP_SRA  = 4'd10,
    OP_SLLV = 4'd11,
    OP_SRLV = 4'd12,
    OP_SRAV = 4'd13,
    OP_RSV0 = 4'd14,
    OP_RSV1 = 4'd15
  } alu_op_e;

  typedef enum logic [1:0] {
    UNIT_ARITH = 2'd0,
    UNIT_LOGIC = 2'd1,
    UNIT_SHIFT = 2'd2,
    UNIT_NONE  = 2'd3
  } alu_unit_e;

  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_OR  = 2'd1,
    LG_XOR = 2'd2,
    LG_NOR = 2'd3
  } logic_fn_e;

  // Strobes from control to datapath
  typedef struct packed {
    alu_unit_e unitSel;
    logic      subtract;
    logic      trapEn;
    logic_fn_e logicFn;
    logic      shiftLeft;
    logic      shiftArith;
    logic      shiftVar;
  } alu_ctrl_t;

endpackage

// File: rtl/alu_trap_ctrl.sv
module alu_trap_ctrl
  import alu_trap_pkg::*;
(
  input  logic [3:0] opCode,
  output alu_ctrl_t  ctrl
);

  alu_op_e op;
  assign op = alu_op_e'(opCode);

  always_comb begin
    ctrl = '{unitSel: UNIT_NONE, subtract: 1'b0, trapEn: 1'b0,
             logicFn: LG_AND, shiftLeft: 1'b0, shiftArith: 1'b0,
             shiftVar: 1'b0};
    unique case (op)
      OP_ADD:  begin ctrl.unitSel = UNIT_ARITH; ctrl.trapEn = 1'b1; end
      OP_ADDU: begin ctrl.unitSel = UNIT_ARITH; end
      OP_SUB:  begin ctrl.unitSel = UNIT_ARITH; ctrl.subtract = 1'b1; ctrl.trapEn = 1'b1; end
      OP_SUBU: begin ctrl.unitSel = UNIT_ARITH; ctrl.subtract = 1'b1; end
      OP_AND:  begin ctrl.unitSel = UNIT_LOGIC; ctrl.logicFn = LG_AND; end
      OP_OR:   begin ctrl.unitSel = UNIT_LOGIC; ctrl.logicFn = LG_OR;  end
      OP_XOR:  begin ctrl.unitSel = UNIT_LOGIC; ctrl.logicFn = LG_XOR; end
      OP_NOR:  begin ctrl.unitSel = UNIT_LOGIC; ctrl.logicFn = LG_NOR; end
      OP_SLL:  begin ctrl.unitSel = UNIT_SHIFT; ctrl.shiftLeft = 1'b1; end
      OP_SRL:  begin ctrl.unitSel = UNIT_SHIFT; end
      OP_SRA:  begin ctrl.unitSel = UNIT_SHIFT; ctrl.shiftArith = 1'b1; end
      OP_SLLV: begin ctrl.unitSel = UNIT_SHIFT; ctrl.shiftLeft = 1'b1; ctrl.shiftVar = 1'b1; end
      OP_SRLV: begin ctrl.unitSel = UNIT_SHIFT; ctrl.shiftVar = 1'b1; end
      OP_SRAV: begin ctrl.unitSel = UNIT_SHIFT; ctrl.shiftArith = 1'b1; ctrl.shiftVar = 1'b1; end
      default: begin ctrl.unitSel = UNIT_NONE; end
    endcase
  end

endmodule

// File: rtl/alu_trap_shifter.sv
module alu_trap_shifter #(
  parameter int DATA_W  = 32,
  parameter int SHAMT_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0]  srcVal,
  input  logic [SHAMT_W-1:0] amount,
  input  logic               goLeft,
  input  logic               arith,
  output logic [DATA_W-1:0]  shifted
);

  logic [DATA_W-1:0] revIn;
  logic [DATA_W-1:0] stageIn;
  logic              fillBit;
  logic [DATA_W-1:0] stage [SHAMT_W+1];

  // Left shifts run through the right shifter on a bit-reversed word
  generate
    for (genvar i = 0; i < DATA_W; i++) begin : g_rev_in
      assign revIn[i] = srcVal[DATA_W-1-i];
    end
  endgenerate

  assign stageIn  = goLeft ? revIn : srcVal;
  assign fillBit  = arith & ~goLeft & srcVal[DATA_W-1];
  assign stage[0] = stageIn;

  generate
    for (genvar s = 0; s < SHAMT_W; s++) begin : g_stage
      localparam int STEP = 2 ** s;
      logic [DATA_W-1:0] fillMask;
      assign fillMask = {DATA_W{fillBit}} << (DATA_W - STEP);
      assign stage[s+1] = amount[s] ? ((stage[s] >> STEP) | fillMask) : stage[s];
    end
  endgenerate

  generate
    for (genvar i = 0; i < DATA_W; i++) begin : g_rev_out
      assign shifted[i] = goLeft ? stage[SHAMT_W][DATA_W-1-i] : stage[SHAMT_W][i];
    end
  endgenerate

endmodule

// File: rtl/alu_trap_dp.sv
module alu_trap_dp
  import alu_trap_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int SHAMT_W = $clog2(DATA_W)
) (
  input  alu_ctrl_t          ctrl,
  input  logic [DATA_W-1:0]  opA,
  input  logic [DATA_W-1:0]  opB,
  input  logic [SHAMT_W-1:0] shamtImm,
  output logic [DATA_W-1:0]  result,
  output logic               ovfTrap
);

  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0]  addB;
  logic [DATA_W-1:0]  sumVal;
  logic               sumOvf;
  logic [DATA_W-1:0]  logicVal;
  logic [DATA_W-1:0]  shiftVal;
  logic [SHAMT_W-1:0] shAmt;

  // Adder: subtract is A + ~B + 1
  assign addB   = ctrl.subtract ? ~opB : opB;
  assign sumVal = opA + addB + {{(DATA_W-1){1'b0}}, ctrl.subtract};
  assign sumOvf = (opA[MSB] == addB[MSB]) && (sumVal[MSB] != opA[MSB]);

  always_comb begin
    unique case (ctrl.logicFn)
      LG_AND:  logicVal = opA & opB;
      LG_OR:   logicVal = opA | opB;
      LG_XOR:  logicVal = opA ^ opB;
      default: logicVal = ~(opA | opB);
    endcase
  end

  assign shAmt = ctrl.shiftVar ? opA[SHAMT_W-1:0] : shamtImm;

  alu_trap_shifter #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W)) u_shifter (
    .srcVal  (opB),
    .amount  (shAmt),
    .goLeft  (ctrl.shiftLeft),
    .arith   (ctrl.shiftArith),
    .shifted (shiftVal)
  );

  always_comb begin
    unique case (ctrl.unitSel)
      UNIT_ARITH: result = sumVal;
      UNIT_LOGIC: result = logicVal;
      UNIT_SHIFT: result = shiftVal;
      default:    result = '0;
    endcase
  end

  assign ovfTrap = (ctrl.unitSel == UNIT_ARITH) && ctrl.trapEn && sumOvf;

endmodule

// File: rtl/alu_trap_top.sv
module alu_trap_top
  import alu_trap_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int SHAMT_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0]  opA,
  input  logic [DATA_W-1:0]  opB,
  input  logic [3:0]         opCode,
  input  logic [SHAMT_W-1:0] shamtImm,
  output logic [DATA_W-1:0]  result,
  output logic               ovfTrap
);

  alu_ctrl_t ctrlBus;

  alu_trap_ctrl u_ctrl (
    .opCode (opCode),
    .ctrl   (ctrlBus)
  );

  alu_trap_dp #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W)) u_dp (
    .ctrl     (ctrlBus),
    .opA      (opA),
    .opB      (opB),
    .shamtImm (shamtImm),
    .result   (result),
    .ovfTrap  (ovfTrap)
  );

endmodule

// File: rtl/alu_trap_chk.sv
module alu_trap_chk #(
  parameter int DATA_W  = 32,
  parameter int SHAMT_W = $clog2(DATA_W)
) (
  input logic [DATA_W-1:0]  opA,
  input logic [DATA_W-1:0]  opB,
  input logic [3:0]         opCode,
  input logic [SHAMT_W-1:0] shamtImm,
  input logic [DATA_W-1:0]  result,
  input logic               ovfTrap
);

  localparam int MSB = DATA_W - 1;

  always_comb begin
    if (!$isunknown({opA, opB, opCode, shamtImm, result, ovfTrap})) begin
      // R2: unsigned forms never trap
      if (opCode == 4'd1 || opCode == 4'd3)
        a_r2_no_overflow: assert (!ovfTrap);

      // R12: logic and shift ops never trap
      if (opCode >= 4'd4 && opCode <= 4'd13)
        a_r12_quiet_ops: assert (!ovfTrap);

      // R11: reserved codes give zero without a trap
      if (opCode >= 4'd14)
        a_r11_reserved_zero: assert (result == '0 && !ovfTrap);

      // R3: an add trap needs same-sign operands and a flipped result sign
      if (opCode == 4'd0 && ovfTrap)
        a_r3_add_trap_cause: assert (opA[MSB] == opB[MSB] && result[MSB] != opA[MSB]);

      // R3: a subtract trap needs differing operand signs
      if (opCode == 4'd2 && ovfTrap)
        a_r3_sub_trap_cause: assert (opA[MSB] != opB[MSB] && result[MSB] != opA[MSB]);

      // R7: arithmetic right shifts keep the sign of opB
      if (opCode == 4'd10 || opCode == 4'd13)
        a_r7_sign_kept: assert (result[MSB] == opB[MSB]);

      // R5: nor relation at the ports
      if (opCode == 4'd7)
        a_r5_nor: assert ((result | opA | opB) == {DATA_W{1'b1}} && (result & (opA | opB)) == '0);
    end
  end

endmodule

bind alu_trap_top alu_trap_chk #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W)) u_alu_trap_chk (
  .opA      (opA),
  .opB      (opB),
  .opCode   (opCode),
  .shamtImm (shamtImm),
  .result   (result),
  .ovfTrap  (ovfTrap)
);

// File: tb/alu_trap_top_bench.sv
module alu_trap_top_bench;

  localparam int DW = 32;
  localparam int SW = 5;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [DW-1:0] opA = '0;
  logic [DW-1:0] opB = '0;
  logic [3:0]    opCode = 4'd0;
  logic [SW-1:0] shamtImm = '0;
  logic [DW-1:0] result;
  logic          ovfTrap;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  alu_trap_top #(.DATA_W(DW), .SHAMT_W(SW)) u_alu_trap_top (
    .opA      (opA),
    .opB      (opB),
    .opCode   (opCode),
    .shamtImm (shamtImm),
    .result   (result),
    .ovfTrap  (ovfTrap)
  );

  task automatic apply(input logic [3:0] op, input logic [DW-1:0] a,
                       input logic [DW-1:0] b, input logic [SW-1:0] sh);
    @(posedge clk);
    opCode = op; opA = a; opB = b; shamtImm = sh;
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [DW-1:0] expRes, input logic expTrap);
    total++;
    if (result !== expRes || ovfTrap !== expTrap) begin
      bad++;
      $display("FAIL %s: result=%h trap=%b expected result=%h trap=%b",
               req, result, ovfTrap, expRes, expTrap);
    end
  endtask

  task automatic t_reset_state();
    apply(4'd0, '0, '0, '0);
    check("R1 reset idle", 32'h0, 1'b0);
  endtask

  task automatic t_r1_signed_arith();
    apply(4'd0, 32'd1234, 32'd4321, '0);       check("R1 add", 32'd5555, 1'b0);
    apply(4'd2, 32'd10, 32'd25, '0);           check("R1 sub neg", 32'hFFFF_FFF1, 1'b0);
    apply(4'd2, 32'h8000_0000, 32'hFFFF_FFFF, '0); check("R1 sub min-(-1)", 32'h8000_0001, 1'b0);
  endtask

  task automatic t_r3_overflow();
    apply(4'd0, 32'h7FFF_FFFF, 32'd1, '0);         check("R3 add pos ovf", 32'h8000_0000, 1'b1);
    apply(4'd0, 32'h8000_0000, 32'h8000_0000, '0); check("R3 add neg ovf", 32'h0, 1'b1);
    apply(4'd0, 32'h7FFF_FFFF, 32'hFFFF_FFFF, '0); check("R3 add mixed sign", 32'h7FFF_FFFE, 1'b0);
    apply(4'd2, 32'h8000_0000, 32'd1, '0);         check("R3 sub ovf", 32'h7FFF_FFFF, 1'b1);
    apply(4'd2, 32'h7FFF_FFFF, 32'hFFFF_FFFF, '0); check("R3 sub ovf pos", 32'h8000_0000, 1'b1);
    apply(4'd2, 32'd0, 32'h8000_0000, '0);         check("R3 sub 0-min", 32'h8000_0000, 1'b1);
    apply(4'd2, 32'hFFFF_FFFF, 32'h8000_0000, '0); check("R3 sub no ovf", 32'h7FFF_FFFF, 1'b0);
  endtask

  task automatic t_r2_unsigned();
    apply(4'd1, 32'h7FFF_FFFF, 32'd1, '0);         check("R2 addu", 32'h8000_0000, 1'b0);
    apply(4'd1, 32'hFFFF_FFFF, 32'd1, '0);         check("R2 addu wrap", 32'h0, 1'b0);
    apply(4'd3, 32'h8000_0000, 32'd1, '0);         check("R2 subu", 32'h7FFF_FFFF, 1'b0);
  endtask

  task automatic t_r9_move();
    apply(4'd0, 32'h0, 32'hDEAD_BEEF, '0);         check("R9 move", 32'hDEAD_BEEF, 1'b0);
    apply(4'd0, 32'h0, 32'h8000_0000, '0);         check("R9 move min", 32'h8000_0000, 1'b0);
  endtask

  task automatic t_r10_neg_const();
    apply(4'd0, 32'd100, 32'hFFFF_FFF9, '0);       check("R10 add -7", 32'd93, 1'b0);
    apply(4'd0, 32'h8000_0003, 32'hFFFF_FFFC, '0); check("R10 add -4 ovf", 32'h7FFF_FFFF, 1'b1);
  endtask

  task automatic t_r4_logic();
    apply(4'd4, 32'hF0F0_1234, 32'hFF00_FF0F, '0); check("R4 and", 32'hF000_1204, 1'b0);
    apply(4'd5, 32'hF0F0_1234, 32'h0F00_0001, '0); check("R4 or", 32'hFFF0_1235, 1'b0);
    apply(4'd6, 32'hAAAA_5555, 32'hFFFF_0000, '0); check("R4 xor", 32'h5555_5555, 1'b0);
    apply(4'd6, 32'h1234_5678, 32'hFFFF_FFFF, '0); check("R4 not via xor", 32'hEDCB_A987, 1'b0);
  endtask

  task automatic t_r5_nor();
    apply(4'd7, 32'h0F0F_0000, 32'h0000_00F0, '0); check("R5 nor", 32'hF0F0_FF0F, 1'b0);
    apply(4'd7, 32'h0, 32'h0, '0);                 check("R5 nor zero", 32'hFFFF_FFFF, 1'b0);
  endtask

  task automatic t_r6_const_shift();
    apply(4'd8, 32'hFFFF_FFFF, 32'h8000_0003, 5'd1);  check("R6 sll 1", 32'h0000_0006, 1'b0);
    apply(4'd8, 32'h0, 32'h0000_0001, 5'd31);         check("R6 sll 31", 32'h8000_0000, 1'b0);
    apply(4'd9, 32'h0, 32'h8000_0000, 5'd31);         check("R6 srl 31", 32'h0000_0001, 1'b0);
    apply(4'd9, 32'h0, 32'hF000_000F, 5'd4);          check("R6 srl 4", 32'h0F00_0000, 1'b0);
    apply(4'd9, 32'h0, 32'hCAFE_F00D, 5'd0);          check("R6 srl 0", 32'hCAFE_F00D, 1'b0);
  endtask

  task automatic t_r7_arith_shift();
    apply(4'd10, 32'h0, 32'h8000_0000, 5'd31);        check("R7 sra 31 neg", 32'hFFFF_FFFF, 1'b0);
    apply(4'd10, 32'h0, 32'hF000_0010, 5'd4);         check("R7 sra 4 neg", 32'hFF00_0001, 1'b0);
    apply(4'd10, 32'h0, 32'h7000_0010, 5'd4);         check("R7 sra 4 pos", 32'h0700_0001, 1'b0);
    apply(4'd13, 32'd1, 32'h8000_0002, 5'd0);         check("R7 srav 1", 32'hC000_0001, 1'b0);
  endtask

  task automatic t_r8_var_shift();
    apply(4'd11, 32'hFFFF_FFE3, 32'h0000_0001, 5'd17); check("R8 sllv upper ignored", 32'h0000_0008, 1'b0);
    apply(4'd12, 32'h0000_0020, 32'h8000_0000, 5'd9);  check("R8 srlv amt 0", 32'h8000_0000, 1'b0);
    apply(4'd12, 32'h0000_001F, 32'hFFFF_FFFF, 5'd0);  check("R8 srlv 31", 32'h0000_0001, 1'b0);
    apply(4'd13, 32'hABCD_0044, 32'h8000_0000, 5'd1);  check("R8 srav 4", 32'hF800_0000, 1'b0);
  endtask

  task automatic t_r11_reserved();
    apply(4'd14, 32'h7FFF_FFFF, 32'd1, 5'd3);          check("R11 code 14", 32'h0, 1'b0);
    apply(4'd15, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'd3);  check("R11 code 15", 32'h0, 1'b0);
  endtask

  task automatic t_r12_no_trap_sweep();
    for (int op = 4; op <= 13; op++) begin
      apply(op[3:0], 32'h7FFF_FFFF, 32'h7FFF_FFFF, 5'd1);
      total++;
      if (ovfTrap !== 1'b0) begin
        bad++;
        $display("FAIL R12 op %0d: trap=%b expected trap=0", op, ovfTrap);
      end
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    t_reset_state();
    t_r1_signed_arith();
    t_r3_overflow();
    t_r2_unsigned();
    t_r9_move();
    t_r10_neg_const();
    t_r4_logic();
    t_r5_nor();
    t_r6_const_shift();
    t_r7_arith_shift();
    t_r8_var_shift();
    t_r11_reserved();
    t_r12_no_trap_sweep();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule